// File: doc/BRIEF.md
# Oneshot/Periodic Interval Timer Channel

This block is a single countdown timer channel clocked by the system clock and advanced by a one-cycle tick enable, normally pulsed at 1 MHz. Software programs it through one control word. That word holds an enable flag, a periodic-reload flag and a 29-bit preset. The preset is the wanted number of ticks minus one. When the down-counter has reached zero and one more tick arrives, the channel raises a level interrupt.

In periodic mode the channel reloads the preset on that same tick and keeps running. A preset of 999 with 1 MHz ticks therefore gives a 1 kHz interrupt. In oneshot mode the enable flag clears itself and the counter rests at zero. Writing zero to the control word stops the channel. A second word, the status word, returns the live count and the pending flag. Writing a one to bit 30 of the status word acknowledges the interrupt.

The register port is a plain single-cycle port. One address bit picks the control or the status word. Reads are combinational.

Top module: `ivt_channel`

## Requirements
- R1: A write to address 0 stores bit 31 as enable, bit 30 as periodic and bits [28:0] as preset. A read of address 0 returns those fields in the same positions, with bit 29 as 0.
- R2: Any write to address 0 loads the counter with the new preset. While enabled, each tick with the counter above zero lowers it by one.
- R3: A tick that finds the channel enabled and the counter at zero sets the interrupt, so one interval lasts preset+1 ticks.
- R4: In periodic mode the counter reloads the preset on the expiry tick, and the channel stays enabled.
- R5: In oneshot mode the enable bit reads 0 after expiry, the counter holds at zero, and further ticks raise no interrupt.
- R6: After a write of 0 to address 0, ticks change neither the counter nor the interrupt.
- R7: The interrupt output is active high and stays high until a write to address 1 with bit 30 set. A status write with bit 30 clear leaves it unchanged.
- R8: An expiry in the same cycle as an acknowledge leaves the interrupt set.
- R9: A read of address 1 returns the live count in bits [28:0] and the pending flag in bit 30. All other bits read 0.
- R10: When a control write and a tick fall in the same cycle, the write wins: the counter takes the new preset with no decrement.
- R11: In a cycle with no tick and no control write, the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle count enable (1 MHz rate) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control word, 1 = status word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the word selected by addr |
| irq | output | 1 | Level interrupt, active high |

## Verification
The properties assume that tick and wr_en are sampled as single-cycle strobes. They also assume that a control write in the same cycle as a tick is a legal case that takes priority. They make no assumption about how often ticks arrive. The stimulus holds each input for exactly one clock and then returns the strobes to zero. It mixes dense and sparse random tick patterns with random control and status writes. Presets are kept mostly small so that many expiries occur, and simultaneous write, tick and acknowledge cases come up both by chance and in directed steps.

// File: rtl/ivt_pkg.sv
// Package: shared widths and bit positions of the interval timer channel.
// Assumes a 32-bit register port; bit positions matter to software.
package ivt_pkg;
    parameter int unsigned DATA_W  = 32;
    parameter int unsigned CNT_W   = 29;
    parameter int unsigned EN_BIT  = 31;
    parameter int unsigned PER_BIT = 30;
    parameter int unsigned ACK_BIT = 30;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic enable;
        logic periodic;
        cnt_t preset;
    } ctrl_t;
endpackage

// File: rtl/ivt_ctrl.sv
// Module: control word store. It holds enable, periodic and preset.
// Assumes that load and stop never both act in one cycle (load wins).
module ivt_ctrl
    import ivt_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         oneshot_done,
    output ctrl_t        ctrl
);
    ctrl_t ctrl_q;

    // Capture a new control word, or drop enable after a oneshot expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (load) begin
            ctrl_q.enable   <= load_word[EN_BIT];
            ctrl_q.periodic <= load_word[PER_BIT];
            ctrl_q.preset   <= load_word[CNT_W-1:0];
        end else if (oneshot_done) begin
            ctrl_q.enable <= 1'b0;
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/ivt_down.sv
// Module: down-counter. It decrements on tick and flags expiry at zero.
// Assumes tick is a one-cycle strobe and load overrides tick.
module ivt_down
    import ivt_pkg::*;
#(
    parameter int unsigned N = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [N-1:0] load_val,
    input  logic         enable,
    input  logic         periodic,
    input  logic [N-1:0] preset,
    output logic [N-1:0] count,
    output logic         expire
);
    localparam logic [N-1:0] ZERO = '0;
    localparam logic [N-1:0] ONE  = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] cnt_q;
    logic         step;

    // A tick counts only when enabled and not overridden by a load.
    always_comb begin
        step   = tick && enable && !load;
        expire = step && (cnt_q == ZERO);
    end

    // Load, reload, hold at zero or decrement the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step) begin
            if (cnt_q == ZERO) begin
                cnt_q <= periodic ? preset : ZERO;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/ivt_flag.sv
// Module: pending interrupt flag. It is set by expiry and cleared by acknowledge.
// Assumes that a set wins over a clear in the same cycle.
module ivt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend
);
    logic pend_q;

    // Hold the level until acknowledged; a new event beats the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (set) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    assign pend = pend_q;
endmodule

// File: rtl/ivt_channel.sv
// Module: top of one interval timer channel. It decodes the two words and wires
// the control store, the down-counter and the pending flag together.
// Assumes single-cycle write strobes; reads are combinational on addr.
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int unsigned W = DATA_W,
    parameter int unsigned N = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic         addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         irq
);
    localparam int unsigned PAD = W - N;

    logic         wr_ctrl;
    logic         wr_stat;
    logic         ack;
    ctrl_t        ctrl;
    logic [N-1:0] count;
    logic         expire;
    logic         pend;

    // Address decode for the two words.
    always_comb begin
        wr_ctrl = wr_en && !addr;
        wr_stat = wr_en && addr;
        ack     = wr_stat && wr_data[ACK_BIT];
    end

    ivt_ctrl #(.W(W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (wr_ctrl),
        .load_word    (wr_data),
        .oneshot_done (expire && !ctrl.periodic),
        .ctrl         (ctrl)
    );

    ivt_down #(.N(N)) u_down (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (wr_ctrl),
        .load_val (wr_data[N-1:0]),
        .enable   (ctrl.enable),
        .periodic (ctrl.periodic),
        .preset   (ctrl.preset),
        .count    (count),
        .expire   (expire)
    );

    ivt_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (expire),
        .clr   (ack),
        .pend  (pend)
    );

    // Read mux; unused bits read zero.
    always_comb begin
        rd_data = '0;
        if (!addr) begin
            rd_data[N-1:0]   = ctrl.preset;
            rd_data[EN_BIT]  = ctrl.enable;
            rd_data[PER_BIT] = ctrl.periodic;
        end else begin
            rd_data[N-1:0]   = count;
            rd_data[ACK_BIT] = pend;
        end
    end

    assign irq = pend;

    logic unused_pad;
    assign unused_pad = (PAD == 0);
endmodule

// File: rtl/ivt_channel_chk.sv
// Module: property checker for ivt_channel, attached by bind below.
module ivt_channel_chk
    import ivt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_en,
    input logic             addr,
    input logic [DATA_W-1:0] wr_data,
    input logic             irq,
    input logic             en,
    input logic             per,
    input logic [CNT_W-1:0] preset,
    input logic [CNT_W-1:0] count
);
    logic wc, ackw, exp_now;
    always_comb begin
        wc      = wr_en && !addr;
        ackw    = wr_en && addr && wr_data[ACK_BIT];
        exp_now = tick && en && !wc && (count == '0);
    end

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wc) |=> $stable(count));
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wc |=> (count == $past(wr_data[CNT_W-1:0])));
    a_r3_expiry_irq: assert property (@(posedge clk) disable iff (!rst_n)
        exp_now |=> irq);
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_now && per) |=> (count == $past(preset)) && en);
    a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_now && !per) |=> (!en && count == '0));
    a_r7_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ackw) |=> irq);
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ackw && !exp_now) |=> !irq);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !exp_now) |=> !irq);
endmodule

bind ivt_channel ivt_channel_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .irq     (irq),
    .en      (ctrl.enable),
    .per     (ctrl.periodic),
    .preset  (ctrl.preset),
    .count   (count)
);

// File: tb/ivt_channel_test.sv
module ivt_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_en, m_per, m_pend;
    logic [28:0] m_pre, m_cnt;

    always #5 clk = ~clk;

    ivt_channel uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl();
        return {m_en, m_per, 1'b0, m_pre};
    endfunction

    function automatic logic [31:0] exp_stat();
        return {1'b0, m_pend, 1'b0, m_cnt};
    endfunction

    // Reference model of one clock edge, written from the requirements.
    task automatic model(input logic w, input logic a, input logic [31:0] d, input logic t);
        logic ld, clr, st, ex;
        ld  = w && !a;
        clr = w && a && d[30];
        st  = t && m_en && !ld;
        ex  = st && (m_cnt == 29'd0);
        if (ld) begin
            m_en = d[31]; m_per = d[30]; m_pre = d[28:0]; m_cnt = d[28:0];
        end else if (st) begin
            if (m_cnt == 29'd0) begin
                if (m_per) m_cnt = m_pre;
                else m_en = 1'b0;
            end else begin
                m_cnt = m_cnt - 29'd1;
            end
        end
        if (ex) m_pend = 1'b1;
        else if (clr) m_pend = 1'b0;
    endtask

    task automatic compare();
        addr = 1'b0; #1;
        check("R1 control readback", rd_data, exp_ctrl());
        addr = 1'b1; #1;
        check("R9 status readback", rd_data, exp_stat());
        check("R7 irq level", {31'd0, irq}, {31'd0, m_pend});
    endtask

    task automatic step(input logic w, input logic a, input logic [31:0] d, input logic t);
        wr_en = w; addr = a; wr_data = d; tick = t;
        @(posedge clk);
        model(w, a, d, t);
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; wr_data = '0;
        compare();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        m_en = 0; m_per = 0; m_pend = 0; m_pre = '0; m_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare();

        // R3/R5: oneshot with preset 3 expires on the fourth tick
        step(1, 0, 32'h8000_0003, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1);
        check("R3 no irq before preset+1 ticks", {31'd0, irq}, 32'd0);
        step(0, 0, 0, 1);
        check("R3 irq on preset+1 tick", {31'd0, irq}, 32'd1);
        addr = 0; #1;
        check("R5 enable cleared after oneshot", {31'd0, rd_data[31]}, 32'd0);
        // R7: ack with bit 30 clear is ignored, set clears
        step(1, 1, 32'hBFFF_FFFF, 0);
        check("R7 ack without bit30 ignored", {31'd0, irq}, 32'd1);
        step(1, 1, 32'h4000_0000, 0);
        check("R7 ack clears irq", {31'd0, irq}, 32'd0);
        // R5: further ticks do nothing
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1);
        check("R5 no irq after oneshot", {31'd0, irq}, 32'd0);

        // R4/R8: periodic preset 2, ack collides with expiry
        step(1, 0, 32'hC000_0002, 0);
        for (int i = 0; i < 2; i++) step(0, 0, 0, 1);
        step(1, 1, 32'h4000_0000, 1);
        check("R8 expiry beats ack", {31'd0, irq}, 32'd1);
        addr = 1; #1;
        check("R4 reload on expiry", {3'd0, rd_data[28:0]}, 32'd2);

        // R6: writing zero stops the channel
        step(1, 1, 32'h4000_0000, 0);
        step(1, 0, 32'h0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
        addr = 1; #1;
        check("R6 stopped count", rd_data, 32'd0);
        check("R6 stopped irq", {31'd0, irq}, 32'd0);

        // R10: write and tick together
        step(1, 0, 32'h8000_0005, 1);
        addr = 1; #1;
        check("R10 load wins over tick", {3'd0, rd_data[28:0]}, 32'd5);
        // R11/R2: hold without tick, decrement with tick
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
        addr = 1; #1;
        check("R11 hold without tick", {3'd0, rd_data[28:0]}, 32'd5);
        step(0, 0, 0, 1);
        addr = 1; #1;
        check("R2 decrement on tick", {3'd0, rd_data[28:0]}, 32'd4);

        // R1: largest preset
        step(1, 0, 32'h9FFF_FFFF, 0);
        addr = 0; #1;
        check("R1 max preset readback", rd_data, 32'h9FFF_FFFF);
        step(1, 0, 32'h0, 0);

        // R3: preset 999 periodic gives 1000 ticks per interrupt
        step(1, 0, 32'hC000_03E7, 0);
        n = 0;
        while (!irq && n < 2000) begin
            step(0, 0, 0, 1);
            n++;
        end
        check("R3 1 kHz interval", n, 1000);
        step(1, 1, 32'h4000_0000, 0);
        n = 0;
        while (!irq && n < 2000) begin
            step(0, 0, 0, 1);
            n++;
        end
        check("R4 periodic second interval", n, 1000);
        step(1, 0, 32'h0, 0);
        step(1, 1, 32'h4000_0000, 0);

        // Random mix against the model (R1, R2, R7, R9 checked every cycle)
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [31:0] d;
            logic t;
            r = int'($urandom_range(0, 99));
            t = (i % 1000 < 500) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 7) == 0);
            if (r < 4) begin
                d = {$urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1'b0,
                     29'($urandom_range(0, 12))};
                step(1, 0, d, t);
            end else if (r < 9) begin
                d = $urandom;
                step(1, 1, d, t);
            end else begin
                step(0, 0, 0, t);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule